// File: doc/BRIEF.md
# Selectable-Source Baud Tick Generator

This block produces the two timing strobes an asynchronous serial port needs: a sampling strobe for the receiver and a bit-rate strobe. Every output is a one-cycle enable in the system clock domain. The block creates no new clock.

A 2-bit selector picks the source of counting events. The choices are every system clock, a fixed divide-by-8 prescaler, or rising edges on an external clock pin. The external pin passes through a two-stage synchroniser before its edges are detected. A programmable 16-bit divisor turns source events into sampling strobes. A second counter then turns sampling strobes into bit-rate strobes, dividing by 16 or by 8 as the oversampling select chooses. In synchronous mode that second division is skipped.

A divisor of zero, or the reserved source code, stops all strobes. When the divisor or the oversampling choice changes, both counters restart at the next source event. No stray strobe is produced when this happens.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is low, and after reset with divisor 0, samp_tick and baud_tick stay 0.
- R2: With src_sel=0 (every system clock), divisor 6, over8=0 and sync_mode=0, samp_tick pulses once every 6 clocks and baud_tick pulses once every 96 clocks.
- R3: With over8=1, baud_tick pulses once every 8 samp_tick pulses. The fastest case is divisor 1 with the system clock, which gives samp_tick on every clock and baud_tick every 8 clocks.
- R4: With src_sel=1, one source event occurs every 8 system clocks, so samp_tick has a period of 8 × divisor clocks.
- R5: With src_sel=3, each rising edge of ext_clk, after synchronisation, is one source event. samp_tick then pulses once every divisor edges.
- R6: src_sel=2 is reserved and produces neither strobe.
- R7: A divisor of 0 produces neither strobe, whatever the source.
- R8: With sync_mode=1, baud_tick has the same period as samp_tick, with one cycle of lag.
- R9: A change of divisor or over8 reloads both counters at the next source event, and that event gives no strobe. With the system clock as source and a change applied before clock edge 1, the first samp_tick is seen after edge divisor+1, and the first baud_tick one cycle after the (16 or 8)-th new sampling strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel | input | 2 | Source: 0 system clock, 1 system clock / 8, 2 reserved, 3 external pin |
| divisor | input | 16 | Source events per sampling strobe; 0 stops the strobes |
| over8 | input | 1 | 1: 8 sampling strobes per bit, 0: 16 |
| sync_mode | input | 1 | 1: bit strobe follows sampling strobe directly |
| ext_clk | input | 1 | External clock pin, asynchronous to clk |
| samp_tick | output | 1 | One-cycle sampling strobe |
| baud_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The main function is exercised by measuring steady-state strobe periods over a grid of settings: each source, small and unit divisors, both oversampling ratios, and synchronous mode. A wrong source choice, a wrong prescaler ratio or a swapped 8/16 ratio each shows up as a different period. The zero-divisor and reserved-source settings are observed to be silent over a long window. A live divisor change and a live ratio change are then timed from the write to the first new strobe of each kind. This timing separates a correct reload from a stray strobe, a counter that is not cleared, and a reload that is delayed.

// File: rtl/baud_tick_gen_pkg.sv
package baud_tick_gen_pkg;
  typedef enum logic [1:0] {
    SRC_SYSCLK = 2'd0,
    SRC_PRESC  = 2'd1,
    SRC_RSVD   = 2'd2,
    SRC_EXTPIN = 2'd3
  } src_sel_e;
endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  // R4: the prescaler never emits two enables in a row
  assert_presc_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/bg_edge_sync.sv
module bg_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick_i,
  input  logic [CW-1:0] cd_i,
  input  logic          over8_i,
  output logic          samp_o,
  output logic          reload_o,
  output logic          over8_o
);
  logic [CW-1:0] cnt_q, cnt_d, cd_q, cd_d;
  logic          over_q, over_d, samp_q, samp_d, rel_q, rel_d;
  logic          cfg_change;

  assign cfg_change = (cd_i != cd_q) || (over8_i != over_q);

  always_comb begin
    cnt_d  = cnt_q;
    cd_d   = cd_q;
    over_d = over_q;
    samp_d = 1'b0;
    rel_d  = 1'b0;
    if (src_tick_i) begin
      if (cfg_change) begin
        cnt_d  = '0;
        cd_d   = cd_i;
        over_d = over8_i;
        rel_d  = 1'b1;
      end else if (cd_q != '0) begin
        if (cnt_q == cd_q - CW'(1)) begin
          cnt_d  = '0;
          samp_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cd_q   <= '0;
      over_q <= 1'b0;
      samp_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cd_q   <= cd_d;
      over_q <= over_d;
      samp_q <= samp_d;
      rel_q  <= rel_d;
    end
  end

  assign samp_o   = samp_q;
  assign reload_o = rel_q;
  assign over8_o  = over_q;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q != '0) |-> (cnt_q < cd_q));
  assert_samp_needs_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> $past(src_tick_i));
  assert_zero_div_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> ($past(cd_i) != '0));
endmodule

// File: rtl/bg_oversamp.sv
module bg_oversamp #(
  parameter int RATIO_HI = 16,
  parameter int RATIO_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,
  input  logic reload_i,
  input  logic over8_i,
  input  logic sync_i,
  output logic baud_o
);
  localparam int CNTW = $clog2(RATIO_HI);

  logic [CNTW-1:0] cnt_q, cnt_d, last;
  logic            baud_q, baud_d;

  assign last = over8_i ? CNTW'(RATIO_LO - 1) : CNTW'(RATIO_HI - 1);

  always_comb begin
    cnt_d  = cnt_q;
    baud_d = 1'b0;
    if (sync_i) begin
      cnt_d  = '0;
      baud_d = samp_i;
    end else if (reload_i) begin
      cnt_d = '0;
    end else if (samp_i) begin
      if (cnt_q >= last) begin
        cnt_d  = '0;
        baud_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      baud_q <= baud_d;
    end
  end

  assign baud_o = baud_q;

  assert_baud_after_samp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    baud_o |-> $past(samp_i));
  assert_sync_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_i) |-> (baud_o == $past(samp_i)));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_gen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESC    = 8,
  parameter int RATIO_HI = 16,
  parameter int RATIO_LO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             over8,
  input  logic             sync_mode,
  input  logic             ext_clk,
  output logic             samp_tick,
  output logic             baud_tick
);
  logic [1:0] rsync_q;
  logic       rst_i;
  logic       pre_tick, ext_rise, src_tick, reload, over_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  bg_prescale #(.DIV(PRESC)) u_presc (
    .clk(clk), .rst_n(rst_i), .tick_o(pre_tick)
  );

  bg_edge_sync u_ext (
    .clk(clk), .rst_n(rst_i), .pin_i(ext_clk), .rise_o(ext_rise)
  );

  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_SYSCLK: src_tick = 1'b1;
      SRC_PRESC:  src_tick = pre_tick;
      SRC_EXTPIN: src_tick = ext_rise;
      default:    src_tick = 1'b0;
    endcase
  end

  bg_divider #(.CW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i), .src_tick_i(src_tick), .cd_i(divisor),
    .over8_i(over8), .samp_o(samp_tick), .reload_o(reload), .over8_o(over_lat)
  );

  bg_oversamp #(.RATIO_HI(RATIO_HI), .RATIO_LO(RATIO_LO)) u_os (
    .clk(clk), .rst_n(rst_i), .samp_i(samp_tick), .reload_i(reload),
    .over8_i(over_lat), .sync_i(sync_mode), .baud_o(baud_tick)
  );

  assert_reserved_silent_R6: assert property (@(posedge clk) disable iff (!rst_i)
    samp_tick |-> ($past(src_sel) != 2'd2));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_i |-> (!samp_tick && !baud_tick));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_sel;
  logic [15:0] divisor;
  logic        over8, sync_mode, ext_clk;
  logic        samp_tick, baud_tick;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  localparam int TO = 700;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .divisor(divisor),
    .over8(over8), .sync_mode(sync_mode), .ext_clk(ext_clk),
    .samp_tick(samp_tick), .baud_tick(baud_tick)
  );

  // external pin: rising edge every 6 system clocks
  initial begin
    ext_clk = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  // columns: src, divisor, over8, sync, samp period, baud period, requirement
  localparam int NV = 9;
  localparam int VEC [NV][7] = '{
    '{0, 6, 0, 0,  6,  96, 2},  // R2
    '{0, 3, 1, 0,  3,  24, 3},  // R3
    '{0, 1, 1, 0,  1,   8, 3},  // R3 fastest
    '{1, 2, 0, 0, 16, 256, 4},  // R4
    '{3, 2, 1, 0, 12,  96, 5},  // R5
    '{2, 5, 0, 0,  0,   0, 6},  // R6
    '{0, 0, 0, 0,  0,   0, 7},  // R7
    '{0, 5, 0, 1,  5,   5, 8},  // R8
    '{1, 1, 1, 1,  8,   8, 8}   // R8 with prescaler
  };

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit which, output int cyc);
    cyc = 0;
    for (int i = 0; i < TO; i++) begin
      @(negedge clk);
      cyc++;
      if ((which ? baud_tick : samp_tick) === 1'b1) return;
    end
    cyc = -1;
  endtask

  task automatic period(input bit which, output int per);
    int c1, c2, c3;
    wait_pulse(which, c1);
    wait_pulse(which, c2);
    wait_pulse(which, c3);
    per = (c1 < 0 || c2 < 0 || c3 < 0) ? 0 : c3;
  endtask

  task automatic count_pulses(input int n, output int ns, output int nb);
    ns = 0; nb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (samp_tick === 1'b1) ns++;
      if (baud_tick === 1'b1) nb++;
    end
  endtask

  task automatic first_after(output int fs, output int fb);
    fs = -1; fb = -1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (samp_tick === 1'b1 && fs < 0) fs = i;
      if (baud_tick === 1'b1 && fb < 0) fb = i;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int ns, nb, ps, pb, fs, fb, c;
    rst_n = 1'b0; src_sel = 2'd0; divisor = 16'd0; over8 = 1'b0; sync_mode = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 samp_tick in reset", int'(samp_tick), 0);
    check("R1 baud_tick in reset", int'(baud_tick), 0);
    rst_n = 1'b1;
    count_pulses(60, ns, nb);
    check("R1 samp pulses after reset, divisor 0", ns, 0);
    check("R1 baud pulses after reset, divisor 0", nb, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      src_sel   = 2'(VEC[v][0]);
      divisor   = 16'(VEC[v][1]);
      over8     = VEC[v][2][0];
      sync_mode = VEC[v][3][0];
      repeat (4) @(negedge clk);
      if (VEC[v][4] == 0) begin
        count_pulses(400, ns, nb);
        check($sformatf("R%0d vec%0d samp count", VEC[v][6], v), ns, 0);
        check($sformatf("R%0d vec%0d baud count", VEC[v][6], v), nb, 0);
      end else begin
        period(1'b0, ps);
        check($sformatf("R%0d vec%0d samp period", VEC[v][6], v), ps, VEC[v][4]);
        period(1'b1, pb);
        check($sformatf("R%0d vec%0d baud period", VEC[v][6], v), pb, VEC[v][5]);
      end
    end

    // R9: divisor change 6 -> 4 right after a bit strobe
    @(negedge clk);
    src_sel = 2'd0; divisor = 16'd6; over8 = 1'b0; sync_mode = 1'b0;
    wait_pulse(1'b1, c);
    wait_pulse(1'b1, c);
    divisor = 16'd4;
    first_after(fs, fb);
    check("R9 first samp after divisor change", fs, 5);
    check("R9 first baud after divisor change", fb, 66);

    // R9: ratio change 16 -> 8 with divisor 4
    wait_pulse(1'b1, c);
    over8 = 1'b1;
    first_after(fs, fb);
    check("R9 first samp after over8 change", fs, 5);
    check("R9 first baud after over8 change", fb, 34);

    finish_run();
  end
endmodule